// File: doc/BRIEF.md
# Streaming run-length byte encoder

This block compresses a stream of 8-bit symbols with run-length coding. Symbols arrive one per handshake on a valid/ready input port. A marker flags the final symbol of a stream. Each maximal run of identical symbols leaves the block as two output bytes: first the run length as an unsigned binary count, then the repeated symbol.

The output port uses the same valid/ready scheme and carries a last marker on the final byte of the stream. A run that would exceed the largest count the count byte can hold is cut into several pairs. Input that seldom repeats can therefore grow to twice its size.

Alongside the byte stream the block keeps a tally of the bytes handed out for the current stream. A system can read it as the compressed length once the last byte has gone out. The tally restarts when the next stream's first symbol is taken. Output backpressure propagates back to the input, so no pair is ever lost.

Top module: `rle_stream_enc`

## Requirements
- R1: Every maximal run of identical input symbols produces exactly one (count, symbol) pair whose count equals the run length, and the pairs appear in input order.
- R2: The count byte is an unsigned binary number in the range 1 to 255 (a run of twelve gives 8'h0C); a count of zero is never emitted.
- R3: Within a pair the count byte is transferred first and the symbol byte second; out_last is high only on the symbol byte of the final pair of a stream.
- R4: A stream with no two equal neighbouring symbols encodes to exactly twice its input length, one count of 1 per symbol.
- R5: A run longer than 255 is emitted as (255, symbol) pairs followed by a pair holding the remainder; a run of exactly 255 yields a single (255, symbol) pair.
- R6: A stream of one symbol s with in_last set encodes to the two bytes 1, s, with out_last on the second.
- R7: While out_valid is high and out_ready is low, out_valid, out_byte and out_last hold their values; input acceptance stalls so that no byte is lost or duplicated under any pattern of out_ready.
- R8: out_total counts the output bytes transferred for the current stream; after the final byte it equals the encoded length (14 for a 67-symbol stream of runs 12,1,12,3,24,1,14).
- R9: out_total reads 0 in the cycle after the first symbol of a new stream is accepted, a new stream being the first symbol after reset or after an accepted in_last.
- R10: After reset out_valid is 0, out_total is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input symbol is present |
| in_ready | output | 1 | Block can take an input symbol this cycle |
| in_sym | input | 8 | Input symbol |
| in_last | input | 1 | Input symbol is the last one of its stream |
| out_valid | output | 1 | Output byte is present |
| out_ready | input | 1 | Downstream takes the output byte this cycle |
| out_byte | output | 8 | Output byte: a run count or a symbol |
| out_last | output | 1 | Output byte is the last one of its stream |
| out_total | output | 32 | Bytes transferred so far for the current stream |

## Verification
The mixed two-symbol stream of 67 bytes checks ordinary runs of differing lengths and the reported length of 14. A non-repeating stream separates correct pair-per-symbol handling from a design that merges neighbours, and brings out the doubling in size. Runs of 255, 256 and 600 symbols probe the boundary of the count byte, where an off-by-one split or a wrapped count shows up. A one-symbol stream tests the flush of a run that ends the moment it begins. Repeated runs under stalling output and gapped input show whether pairs are lost, repeated or changed while held.

// File: rtl/rle_pkg.sv
// Package: shared types of the run-length encoder.
// Assumes: nothing beyond the encoder's own modules uses these.
package rle_pkg;

    // Output serializer phase: idle, count byte on the port, symbol byte on the port.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CNT  = 2'd1,
        PH_SYM  = 2'd2
    } emit_phase_e;

endpackage

// File: rtl/rle_run_track.sv
// Module: rle_run_track
// Tracks the open run (symbol, length) and decides when a (count, symbol)
// pair must be handed to the output serializer: on a symbol change, on a
// count that would pass its maximum, and on the stream's last symbol.
// Assumes: acc_i is only raised when the serializer is free and no final
// flush is pending (the top derives in_ready from busy_o and emit_free_i).
module rle_run_track #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic [BYTE_W-1:0] sym_i,
    input  logic              last_i,
    input  logic              emit_free_i,
    output logic              push_o,
    output logic [BYTE_W-1:0] pcnt_o,
    output logic [BYTE_W-1:0] psym_o,
    output logic              plast_o,
    output logic              busy_o,
    output logic              open_o
);

    localparam logic [BYTE_W-1:0] CNT_MAX = {BYTE_W{1'b1}};
    localparam logic [BYTE_W-1:0] CNT_ONE = BYTE_W'(1);

    logic [BYTE_W-1:0] sym_q;
    logic [BYTE_W-1:0] cnt_q;
    logic              open_q;
    logic              flush_q;

    logic extend;
    logic brk;
    logic flush;
    logic fin;

    // Classify the accepted symbol against the open run.
    always_comb begin
        extend = open_q && (sym_i == sym_q) && (cnt_q != CNT_MAX);
        brk    = acc_i && open_q && !extend;
        flush  = flush_q && emit_free_i;
        fin    = acc_i && last_i && !brk;
    end

    // Select the pair handed to the serializer this cycle.
    always_comb begin
        push_o  = flush || brk || fin;
        plast_o = flush || fin;
        psym_o  = (flush || brk) ? sym_q : sym_i;
        if (flush || brk)
            pcnt_o = cnt_q;
        else if (open_q)
            pcnt_o = cnt_q + 1'b1;
        else
            pcnt_o = CNT_ONE;
    end

    // Update the open run and the pending final flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q   <= '0;
            cnt_q   <= '0;
            open_q  <= 1'b0;
            flush_q <= 1'b0;
        end else if (flush) begin
            open_q  <= 1'b0;
            flush_q <= 1'b0;
        end else if (acc_i) begin
            if (fin) begin
                open_q <= 1'b0;
            end else if (brk || !open_q) begin
                sym_q   <= sym_i;
                cnt_q   <= CNT_ONE;
                open_q  <= 1'b1;
                flush_q <= last_i;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy_o = flush_q;
    assign open_o = open_q;

    // An open run never carries a zero length.
    assert_run_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> (cnt_q != '0));

    // No symbol is taken while the final pair still waits.
    assert_flush_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_q |-> !acc_i);

    // A full run met by its own symbol is closed with the maximum count.
    assert_split_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_i && open_q && sym_i == sym_q && cnt_q == CNT_MAX)
            |-> (push_o && pcnt_o == CNT_MAX));

    // A pending flush is always followed by an idle run.
    assert_flush_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_q && emit_free_i) |=> (!open_q && !flush_q));

endmodule

// File: rtl/rle_pair_emit.sv
// Module: rle_pair_emit
// Holds one (count, symbol) pair and sends it as two output beats, count
// first. It can take a new pair in the cycle its symbol beat leaves.
// Assumes: push_i is only raised while free_o is high.
module rle_pair_emit
    import rle_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [BYTE_W-1:0] cnt_i,
    input  logic [BYTE_W-1:0] sym_i,
    input  logic              last_i,
    input  logic              out_ready_i,
    output logic              out_valid_o,
    output logic [BYTE_W-1:0] out_byte_o,
    output logic              out_last_o,
    output logic              free_o,
    output logic              beat_o
);

    emit_phase_e       phase_q;
    logic [BYTE_W-1:0] cnt_q;
    logic [BYTE_W-1:0] sym_q;
    logic              last_q;

    // Drive the output beat from the current phase.
    always_comb begin
        out_valid_o = (phase_q != PH_IDLE);
        out_byte_o  = (phase_q == PH_CNT) ? cnt_q : sym_q;
        out_last_o  = (phase_q == PH_SYM) && last_q;
        beat_o      = out_valid_o && out_ready_i;
        free_o      = (phase_q == PH_IDLE) || ((phase_q == PH_SYM) && out_ready_i);
    end

    // Load a pair or step through its two beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            sym_q   <= '0;
            last_q  <= 1'b0;
        end else if (push_i) begin
            phase_q <= PH_CNT;
            cnt_q   <= cnt_i;
            sym_q   <= sym_i;
            last_q  <= last_i;
        end else if (out_ready_i) begin
            case (phase_q)
                PH_CNT:  phase_q <= PH_SYM;
                PH_SYM:  phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // A pair is never loaded over one still being sent.
    assert_push_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> free_o);

    // A stalled beat holds its value and marker.
    assert_hold_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i)
            |=> (out_valid_o && $stable(out_byte_o) && $stable(out_last_o)));

    // A count beat that leaves is followed by a symbol beat.
    assert_count_then_sym_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CNT && out_ready_i) |=> (out_valid_o && phase_q == PH_SYM));

    // The count beat never carries zero.
    assert_count_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CNT) |-> (out_byte_o != '0));

endmodule

// File: rtl/rle_byte_tally.sv
// Module: rle_byte_tally
// Counts transferred output bytes of the current stream; a clear wins
// over a beat in the same cycle because that beat closes the old stream.
// Assumes: the counter is wide enough for the longest stream.
module rle_byte_tally #(
    parameter int TOT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             beat_i,
    output logic [TOT_W-1:0] total_o
);

    logic [TOT_W-1:0] total_q;

    // Clear on a new stream, else step on each transferred byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            total_q <= '0;
        else if (clear_i)
            total_q <= '0;
        else if (beat_i)
            total_q <= total_q + 1'b1;
    end

    assign total_o = total_q;

    // A new stream starts from zero.
    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (total_o == '0));

    // Without a byte or a clear the tally does not move.
    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !beat_i) |=> $stable(total_o));

endmodule

// File: rtl/rle_stream_enc.sv
// Module: rle_stream_enc (top)
// Streaming run-length encoder: symbols in, (count, symbol) byte pairs out,
// with a per-stream tally of output bytes.
// Assumes: in_sym and in_last are stable while in_valid waits for in_ready.
module rle_stream_enc #(
    parameter int BYTE_W = 8,
    parameter int TOT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_sym,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_last,
    output logic [TOT_W-1:0]  out_total
);

    logic              acc;
    logic              push;
    logic [BYTE_W-1:0] pcnt;
    logic [BYTE_W-1:0] psym;
    logic              plast;
    logic              busy;
    logic              run_open;
    logic              emit_free;
    logic              beat;
    logic              clear;

    // Accept a symbol only when any pair it may close has room.
    always_comb begin
        in_ready = !busy && emit_free;
        acc      = in_valid && in_ready;
        clear    = acc && !run_open;
    end

    rle_run_track #(.BYTE_W(BYTE_W)) run_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_i       (acc),
        .sym_i       (in_sym),
        .last_i      (in_last),
        .emit_free_i (emit_free),
        .push_o      (push),
        .pcnt_o      (pcnt),
        .psym_o      (psym),
        .plast_o     (plast),
        .busy_o      (busy),
        .open_o      (run_open)
    );

    rle_pair_emit #(.BYTE_W(BYTE_W)) emit_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .cnt_i       (pcnt),
        .sym_i       (psym),
        .last_i      (plast),
        .out_ready_i (out_ready),
        .out_valid_o (out_valid),
        .out_byte_o  (out_byte),
        .out_last_o  (out_last),
        .free_o      (emit_free),
        .beat_o      (beat)
    );

    rle_byte_tally #(.TOT_W(TOT_W)) tally_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .beat_i  (beat),
        .total_o (out_total)
    );

    // Nothing comes out right after reset.
    assert_reset_idle_R10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_total == '0));

endmodule

// File: tb/rle_stream_enc_tb_top.sv
// Directed bench for rle_stream_enc: one task per scenario.
module rle_stream_enc_tb_top;

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_sym;
    logic        in_last;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_byte;
    logic        out_last;
    logic [31:0] out_total;

    int total_checks = 0;
    int bad_checks   = 0;

    logic [7:0] stim [0:1023];
    logic [7:0] expb [0:2047];
    logic [7:0] rxb  [0:2047];
    int         n_in;
    int         n_exp;

    rle_stream_enc dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_sym    (in_sym),
        .in_last   (in_last),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_byte  (out_byte),
        .out_last  (out_last),
        .out_total (out_total)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total_checks++;
        if (!ok) begin
            bad_checks++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference encoder computed from the requirements.
    task automatic encode();
        int i = 0;
        n_exp = 0;
        while (i < n_in) begin
            int r = 1;
            while (i + r < n_in && stim[i + r] == stim[i] && r < 255) r++;
            expb[n_exp]     = 8'(r);
            expb[n_exp + 1] = stim[i];
            n_exp += 2;
            i += r;
        end
    endtask

    task automatic fill_run(input int start, input int len, input logic [7:0] s);
        for (int k = 0; k < len; k++) stim[start + k] = s;
    endtask

    // Send stim[0..n_in-1]; mode 0 free flow, 1 light stall, 2 heavy stall and input gaps.
    task automatic run_stream(input int mode, input string req);
        int  idx = 0;
        int  rxn = 0;
        int  lastpos = -1;
        int  cyc = 0;
        int  viol = 0;
        int  mism = 0;
        bit  done = 0;
        bit  want_clear = 0;
        bit  first = 1;
        bit  prev_stall = 0;
        logic [7:0] prev_byte = 8'h00;
        logic prev_last = 1'b0;
        encode();
        while (!done && cyc < 20000) begin
            @(negedge clk);
            if (want_clear) begin
                check(out_total == 32'd0, "R9 total cleared on new stream", int'(out_total), 0);
                want_clear = 0;
            end
            if (prev_stall && (!out_valid || out_byte != prev_byte || out_last != prev_last)) viol++;
            in_valid  = (idx < n_in) && (mode != 2 || (cyc % 4) != 3);
            in_sym    = (idx < n_in) ? stim[idx] : 8'h00;
            in_last   = (idx == n_in - 1);
            out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? ((cyc % 3) != 0) : ((cyc % 5) == 0);
            #1;
            prev_stall = out_valid && !out_ready;
            prev_byte  = out_byte;
            prev_last  = out_last;
            if (out_valid && out_ready) begin
                if (rxn < 2048) rxb[rxn] = out_byte;
                if (out_last) begin
                    lastpos = rxn;
                    done = 1;
                end
                rxn++;
            end
            if (in_valid && in_ready) begin
                if (first) want_clear = 1;
                first = 0;
                idx++;
            end
            @(posedge clk);
            cyc++;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = 1'b0;
        check(rxn == n_exp, {req, " encoded length"}, rxn, n_exp);
        for (int k = 0; k < n_exp && k < rxn; k++)
            if (rxb[k] != expb[k]) mism++;
        check(mism == 0, {req, " R1 pair bytes match"}, mism, 0);
        check(lastpos == n_exp - 1, {req, " R3 last on final symbol byte"}, lastpos, n_exp - 1);
        check(out_total == 32'(n_exp), {req, " R8 total equals length"}, int'(out_total), n_exp);
        check(viol == 0, {req, " R7 stalled beat held"}, viol, 0);
    endtask

    task automatic test_reset();
        check(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
        check(out_total == 32'd0, "R10 out_total after reset", int'(out_total), 0);
        check(in_ready == 1'b1, "R10 in_ready after reset", int'(in_ready), 1);
    endtask

    task automatic test_mixed();
        n_in = 0;
        fill_run(n_in, 12, "W"); n_in += 12;
        fill_run(n_in, 1,  "B"); n_in += 1;
        fill_run(n_in, 12, "W"); n_in += 12;
        fill_run(n_in, 3,  "B"); n_in += 3;
        fill_run(n_in, 24, "W"); n_in += 24;
        fill_run(n_in, 1,  "B"); n_in += 1;
        fill_run(n_in, 14, "W"); n_in += 14;
        run_stream(0, "R8 mixed67");
        check(n_exp == 14 && expb[0] == 8'h0C, "R2 reference count of twelve", int'(expb[0]), 12);
    endtask

    task automatic test_alternating();
        n_in = 12;
        for (int k = 0; k < 12; k++) stim[k] = 8'("A") + 8'(k % 3);
        run_stream(0, "R4 alternating");
        check(n_exp == 24, "R4 doubled size", n_exp, 24);
    endtask

    task automatic test_single();
        n_in = 1;
        stim[0] = 8'h5A;
        run_stream(0, "R6 single");
    endtask

    task automatic test_long_runs();
        n_in = 255; fill_run(0, 255, 8'h11);
        run_stream(1, "R5 run255");
        n_in = 256; fill_run(0, 256, 8'h22);
        run_stream(1, "R5 run256");
        n_in = 600; fill_run(0, 600, 8'h33);
        run_stream(0, "R5 run600");
    endtask

    task automatic test_backpressure();
        n_in = 0;
        for (int k = 0; k < 40; k++) begin
            fill_run(n_in, (k % 4) + 1, 8'(k % 2 ? 8'h7E : 8'h00) + 8'(k / 8));
            n_in += (k % 4) + 1;
        end
        run_stream(2, "R7 heavy stall");
        run_stream(1, "R7 light stall");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_sym    = 8'h00;
        in_last   = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        test_reset();
        test_mixed();
        test_alternating();
        test_single();
        test_long_runs();
        test_backpressure();
        $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
        $finish;
    end

endmodule